// File: doc/BRIEF.md
# Multiplexed Row/Column Address Memory

This block is a small synchronous memory model whose word address arrives in two phases over one narrow shared bus. A rising row strobe captures the whole bus as the row number and opens that row. A later rising column strobe takes the low part of the bus as the column number and performs one access of a 4-bit word in the open row. The access is a write or a read, chosen by an active-low write enable and an active-high read enable. Dropping the row strobe closes the row. A column strobe with no open row, or with both controls asking for conflicting operations, raises a one-cycle protocol-error flag and leaves the array alone.

The shared bus is as wide as the row field. Widths are parameters. The full-size setting is `ROW_W=12`, `COL_W=10`, giving 22 address bits, 4,194,304 words of 4 bits (16 Mbit), and four times as many rows as columns. The default setting keeps the same 4:1 shape at a size a bench can sweep: `ROW_W=5` and `COL_W=3`, giving 32 rows by 8 columns. All inputs are sampled on the rising clock edge. A strobe "rises" when it is sampled high after being sampled low at the previous edge.

Top module: `mux_addr_mem`

## Requirements
- R1: While `rst_n` is low, and after it is released with no access made, `dout` is 0 and `proto_err` is 0. No row is open until a row strobe rises.
- R2: On a rising `row_stb`, the full `addr_bus` is captured as the row. Changes on `addr_bus` while the row stays open do not change which row later column accesses use.
- R3: A rising `col_stb` while a row is open, with `we_n`=0 and `rd_en`=0, stores `din` at (open row, column). A row is open when `row_stb` was high at the previous edge and is still high.
- R4: A rising `col_stb` while a row is open, with `we_n`=1 and `rd_en`=1, puts the stored word on `dout` right after that edge. `dout` then holds until the next read.
- R5: The column is the low `COL_W` bits of `addr_bus`. The upper `ROW_W-COL_W` bits are ignored during the column phase.
- R6: Several column accesses may follow one another within one open row, each addressing its own column.
- R7: A rising `col_stb` with no open row raises `proto_err` for exactly the one cycle after that edge. This covers `row_stb` low, and `row_stb` rising in that same cycle. No write occurs and `dout` does not change.
- R8: Deasserting `row_stb` closes the row. A column strobe after that is a protocol error (R7) until a new row strobe rises.
- R9: A rising `col_stb` on an open row with `we_n`=0 and `rd_en`=1 raises `proto_err` and writes nothing. With `we_n`=1 and `rd_en`=0 it does nothing and raises no error.
- R10: Holding `col_stb` high performs only the one access at its rising edge. A `din` change while the strobe stays high is not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_bus | input | ROW_W | Shared address bus: row in phase one, column in its low bits in phase two |
| row_stb | input | 1 | Row strobe; rising edge opens a row, low closes it |
| col_stb | input | 1 | Column strobe; rising edge starts one access |
| we_n | input | 1 | Write enable, active low |
| rd_en | input | 1 | Read enable, active high |
| din | input | DATA_W | Write data |
| dout | output | DATA_W | Read data, registered, held between reads |
| proto_err | output | 1 | One-cycle pulse on a refused column access |

## Verification
The assertions assume that `row_stb` and `col_stb` are held low during reset, and that each strobe is a clean level sampled once per clock. Under these assumptions, a rise is detected against the previous sampled value. The bench changes every input only on the falling edge. It returns `col_stb` low for at least one edge between accesses, except in the deliberate held-strobe case. It never raises a strobe during reset, so every edge the design sees is one the bench intended. Each refused-access case keeps `row_stb` at a known level, so the open-row state the error depends on is fixed.

// File: rtl/mux_addr_mem_pkg.sv
package mux_addr_mem_pkg;

  typedef enum logic [1:0] {
    ACC_NONE  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_READ  = 2'd2,
    ACC_FAULT = 2'd3
  } acc_kind_t;

  // Decode of the two control pins into the requested operation.
  function automatic acc_kind_t ctl_decode(input logic we_n, input logic rd_en);
    if (!we_n && !rd_en)     return ACC_WRITE;
    else if (we_n && rd_en)  return ACC_READ;
    else if (!we_n && rd_en) return ACC_FAULT;
    else                     return ACC_NONE;
  endfunction

endpackage

// File: rtl/rc_strobe_ctrl.sv
module rc_strobe_ctrl
  import mux_addr_mem_pkg::*;
#(
  parameter int ROW_W = 5,
  parameter int COL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ROW_W-1:0] addr_bus,
  input  logic             row_stb,
  input  logic             col_stb,
  input  logic             we_n,
  input  logic             rd_en,
  output logic [ROW_W-1:0] row_sel,
  output logic [COL_W-1:0] col_sel,
  output acc_kind_t        acc_kind,
  output logic             row_open
);

  function automatic logic [COL_W-1:0] col_field(input logic [ROW_W-1:0] bus);
    return bus[COL_W-1:0];
  endfunction

  logic row_prev_q;
  logic col_prev_q;
  logic [ROW_W-1:0] row_q;

  logic row_rise_w;
  logic col_rise_w;
  logic open_w;
  acc_kind_t req_w;

  assign row_rise_w = row_stb & ~row_prev_q;
  assign col_rise_w = col_stb & ~col_prev_q;
  assign open_w     = row_prev_q & row_stb;
  assign req_w      = ctl_decode(we_n, rd_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_prev_q <= 1'b0;
      col_prev_q <= 1'b0;
      row_q      <= '0;
    end else begin
      row_prev_q <= row_stb;
      col_prev_q <= col_stb;
      if (row_rise_w) row_q <= addr_bus;
    end
  end

  always_comb begin
    acc_kind = ACC_NONE;
    if (col_rise_w) begin
      if (!open_w) acc_kind = ACC_FAULT;
      else         acc_kind = req_w;
    end
  end

  assign row_sel  = row_q;
  assign col_sel  = col_field(addr_bus);
  assign row_open = open_w;

  // R2
  row_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (row_prev_q && row_stb) |=> $stable(row_q));

  // R8
  row_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !row_stb |=> !row_open);

  // R10
  single_shot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (col_stb && $past(col_stb)) |-> (acc_kind == ACC_NONE));

endmodule

// File: rtl/rc_cell_array.sv
module rc_cell_array
  import mux_addr_mem_pkg::*;
#(
  parameter int ROW_W  = 5,
  parameter int COL_W  = 3,
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ROW_W-1:0]  row_sel,
  input  logic [COL_W-1:0]  col_sel,
  input  logic              wr_fire,
  input  logic              rd_fire,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);

  localparam int IDX_W = ROW_W + COL_W;
  localparam int DEPTH = 1 << IDX_W;

  function automatic logic [IDX_W-1:0] word_index(input logic [ROW_W-1:0] r,
                                                  input logic [COL_W-1:0] c);
    return {r, c};
  endfunction

  logic [DATA_W-1:0] cells [DEPTH];
  logic [DATA_W-1:0] dout_q;
  logic [IDX_W-1:0]  idx_w;

  assign idx_w = word_index(row_sel, col_sel);

  always_ff @(posedge clk) begin
    if (wr_fire) cells[idx_w] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       dout_q <= '0;
    else if (rd_fire) dout_q <= cells[idx_w];
  end

  assign dout = dout_q;

  // R4
  dout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_fire |=> $stable(dout));

  // R3
  no_dual_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_fire && rd_fire));

endmodule

// File: rtl/mux_addr_mem.sv
module mux_addr_mem
  import mux_addr_mem_pkg::*;
#(
  parameter int ROW_W  = 5,
  parameter int COL_W  = 3,
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ROW_W-1:0]  addr_bus,
  input  logic              row_stb,
  input  logic              col_stb,
  input  logic              we_n,
  input  logic              rd_en,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              proto_err
);

  logic [ROW_W-1:0] row_sel_w;
  logic [COL_W-1:0] col_sel_w;
  acc_kind_t        acc_kind_w;
  logic             row_open_w;
  logic             wr_fire_w;
  logic             rd_fire_w;
  logic             err_fire_w;
  logic             err_q;

  rc_strobe_ctrl #(.ROW_W(ROW_W), .COL_W(COL_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr_bus (addr_bus),
    .row_stb  (row_stb),
    .col_stb  (col_stb),
    .we_n     (we_n),
    .rd_en    (rd_en),
    .row_sel  (row_sel_w),
    .col_sel  (col_sel_w),
    .acc_kind (acc_kind_w),
    .row_open (row_open_w)
  );

  assign wr_fire_w  = (acc_kind_w == ACC_WRITE);
  assign rd_fire_w  = (acc_kind_w == ACC_READ);
  assign err_fire_w = (acc_kind_w == ACC_FAULT);

  rc_cell_array #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W)) u_array (
    .clk     (clk),
    .rst_n   (rst_n),
    .row_sel (row_sel_w),
    .col_sel (col_sel_w),
    .wr_fire (wr_fire_w),
    .rd_fire (rd_fire_w),
    .din     (din),
    .dout    (dout)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_fire_w;
  end

  assign proto_err = err_q;

  // R7
  closed_col_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (col_stb && !$past(col_stb) && !row_open_w) |=> proto_err);

  // R7
  err_no_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |-> !$past(wr_fire_w) && !$past(rd_fire_w));

  // R9
  conflict_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (col_stb && !$past(col_stb) && !we_n && rd_en) |=> proto_err);

endmodule

// File: tb/mux_addr_mem_bench.sv
module mux_addr_mem_bench;

  localparam int ROW_W  = 5;
  localparam int COL_W  = 3;
  localparam int DATA_W = 4;
  localparam int ROWS   = 1 << ROW_W;
  localparam int COLS   = 1 << COL_W;
  localparam int CLK_PERIOD = 10;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [ROW_W-1:0]  addr_bus = '0;
  logic              row_stb = 1'b0;
  logic              col_stb = 1'b0;
  logic              we_n = 1'b1;
  logic              rd_en = 1'b0;
  logic [DATA_W-1:0] din = '0;
  logic [DATA_W-1:0] dout;
  logic              proto_err;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mux_addr_mem #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W)) u_mux_addr_mem (
    .clk(clk), .rst_n(rst_n), .addr_bus(addr_bus), .row_stb(row_stb),
    .col_stb(col_stb), .we_n(we_n), .rd_en(rd_en), .din(din),
    .dout(dout), .proto_err(proto_err)
  );

  function automatic logic [DATA_W-1:0] pat(input int r, input int c);
    return DATA_W'((r * 3 + c * 5 + 1) % 16);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic open_row(input int r);
    addr_bus = ROW_W'(r);
    row_stb  = 1'b1;
    @(negedge clk);
  endtask

  task automatic close_row();
    row_stb = 1'b0;
    @(negedge clk);
  endtask

  // One column strobe pulse; outputs sampled on the negedge after the edge.
  task automatic col_pulse(input int bus, input logic wn, input logic re,
                           input int d, output int q, output int e);
    addr_bus = ROW_W'(bus);
    we_n = wn; rd_en = re; din = DATA_W'(d);
    col_stb = 1'b1;
    @(negedge clk);
    q = int'(dout); e = int'(proto_err);
    col_stb = 1'b0; we_n = 1'b1; rd_en = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    int q, e, q0;
    @(negedge clk);
    chk("R1 dout in reset", int'(dout), 0);
    chk("R1 err in reset", int'(proto_err), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 dout after reset", int'(dout), 0);
    chk("R1 err after reset", int'(proto_err), 0);

    // R3 / R6: fill every word, page mode within each row
    for (int r = 0; r < ROWS; r++) begin
      open_row(r);
      for (int c = 0; c < COLS; c++) begin
        col_pulse(c, 1'b0, 1'b0, int'(pat(r, c)), q, e);
        if (c == 0) chk("R3 write no err", e, 0);
      end
      close_row();
    end
    // R4 / R6: read all words back
    for (int r = 0; r < ROWS; r++) begin
      open_row(r);
      for (int c = 0; c < COLS; c++) begin
        col_pulse(c, 1'b1, 1'b1, 0, q, e);
        chk("R4 R6 read data", q, int'(pat(r, c)));
        if (c == 0) chk("R4 read no err", e, 0);
      end
      close_row();
    end

    // R4: dout holds after read through idle cycles
    open_row(2);
    col_pulse(5, 1'b1, 1'b1, 0, q, e);
    repeat (3) @(negedge clk);
    chk("R4 dout holds", int'(dout), int'(pat(2, 5)));
    close_row();

    // R5: upper bus bits ignored in column phase
    open_row(7);
    col_pulse((3 << COL_W) | 4, 1'b0, 1'b0, 4'hA, q, e);
    col_pulse(4, 1'b1, 1'b1, 0, q, e);
    chk("R5 upper bits ignored", q, 4'hA);
    col_pulse((2 << COL_W) | 4, 1'b1, 1'b1, 0, q, e);
    chk("R5 upper bits ignored read", q, 4'hA);
    col_pulse(3, 1'b1, 1'b1, 0, q, e);
    chk("R5 neighbour untouched", q, int'(pat(7, 3)));
    close_row();

    // R2: bus change during open row does not move the row
    open_row(9);
    addr_bus = ROW_W'(20);
    @(negedge clk);
    col_pulse(1, 1'b1, 1'b1, 0, q, e);
    chk("R2 row held", q, int'(pat(9, 1)));
    close_row();

    // R7: column strobe with row strobe low
    q0 = int'(dout);
    addr_bus = ROW_W'(1); we_n = 1'b0; rd_en = 1'b0; din = 4'h0; col_stb = 1'b1;
    @(negedge clk);
    chk("R7 err no row", int'(proto_err), 1);
    chk("R7 dout unchanged", int'(dout), q0);
    col_stb = 1'b0; we_n = 1'b1;
    @(negedge clk);
    chk("R7 err one cycle", int'(proto_err), 0);
    open_row(9);
    col_pulse(1, 1'b1, 1'b1, 0, q, e);
    chk("R7 no write when closed", q, int'(pat(9, 1)));
    close_row();

    // R7: row and column strobes rise together
    addr_bus = ROW_W'(4); row_stb = 1'b1; col_stb = 1'b1; we_n = 1'b0; din = 4'h0;
    @(negedge clk);
    chk("R7 same-cycle err", int'(proto_err), 1);
    col_stb = 1'b0; we_n = 1'b1;
    @(negedge clk);
    close_row();
    open_row(4);
    col_pulse(4, 1'b1, 1'b1, 0, q, e);
    chk("R7 same-cycle no write", q, int'(pat(4, 4)));
    close_row();

    // R8: row closed then column strobe
    open_row(11);
    close_row();
    col_pulse(2, 1'b1, 1'b1, 0, q, e);
    chk("R8 closed row err", e, 1);
    chk("R8 closed row dout", q, int'(pat(4, 4)));

    // R9: conflicting controls and idle controls
    open_row(12);
    col_pulse(6, 1'b0, 1'b1, 4'h0, q, e);
    chk("R9 conflict err", e, 1);
    col_pulse(6, 1'b1, 1'b0, 0, q, e);
    chk("R9 idle no err", e, 0);
    chk("R9 idle dout unchanged", q, int'(pat(4, 4)));
    col_pulse(6, 1'b1, 1'b1, 0, q, e);
    chk("R9 conflict no write", q, int'(pat(12, 6)));
    close_row();

    // R10: held column strobe stores only the first din
    open_row(15);
    addr_bus = ROW_W'(0); we_n = 1'b0; rd_en = 1'b0; din = 4'h3; col_stb = 1'b1;
    @(negedge clk);
    din = 4'hC;
    @(negedge clk);
    din = 4'h9;
    @(negedge clk);
    col_stb = 1'b0; we_n = 1'b1;
    @(negedge clk);
    col_pulse(0, 1'b1, 1'b1, 0, q, e);
    chk("R10 single access", q, 4'h3);
    close_row();

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule